// File: doc/BRIEF.md
# Serial Character Receiver with Error Flags

This block takes characters from a single serial data line and places each completed character into a holding register for the surrounding logic to collect. It works in one of two timing modes. In synchronous mode each bit is taken on a rising edge of an external serial clock. In asynchronous mode the line is oversampled with a strobe that pulses a fixed number of times per bit. In that mode the falling edge of a start bit is checked again at mid-bit, so a short low pulse is rejected.

A character has a start bit, then 5 to 8 data bits sent least significant bit first, then an optional parity bit, then one stop bit. The receiver reports four flags: a character is waiting, a character was lost because the previous one was not collected, the parity did not match, and the stop bit was missing. A framing error is reported only when at least one data bit was high, so an all-zero break character does not raise it. A read strobe collects the character. A separate clear pulse resets the three error flags.

Top module: `serial_rx_core`

## Requirements
- R1: `rx_data` and `rdy` change only after the stop bit has been sampled. Before that point in a frame, both keep their earlier values. After it, `rdy` is 1 and `rx_data` holds the new character. After reset, all outputs are 0.
- R2: When a character completes while `rdy` is still 1 and no read strobe arrives in that cycle, `ovr` is set to 1.
- R3: `parity_mode` selects the parity rule. 0 means even: the parity bit equals the XOR of the data bits. 1 means odd: the parity bit is the inverse of that XOR. 2 means the parity bit must be 0. 3 means it must be 1. If the received parity bit differs from the expected value, `par_err` is set.
- R4: `parity_mode` values 4 to 7 mean no parity. No parity bit is expected, the stop bit follows the last data bit directly, and `par_err` is never set.
- R5: `frm_err` is set when the stop bit is sampled low and at least one data bit was 1. A low stop bit with all data bits 0 (a break) leaves `frm_err` unchanged.
- R6: A one-cycle `rd_strobe` clears `rdy` at the next clock edge.
- R7: `ovr`, `par_err` and `frm_err` stay set until a `clr_status` pulse clears all three. Later error-free characters do not clear them.
- R8: `data_bits_cfg` selects 5, 6, 7 or 8 data bits for the values 0, 1, 2 and 3. The first received bit goes to `rx_data[0]`. Bits above the selected count read as 0.
- R9: With `sync_mode` at 1, a low level at a rising edge of `sclk` while the receiver is idle starts a frame. Each following rising edge samples one bit.
- R10: With `sync_mode` at 0, `tick` pulses OVS times per bit. A low line is confirmed as a start bit OVS/2 ticks later. If the line is high again by then, it is ignored. After a frame, a new start is accepted only once the line has been seen high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sync_mode | input | 1 | 1: sample on `sclk` rising edges; 0: oversample using `tick` |
| sclk | input | 1 | External serial clock (synchronous mode) |
| tick | input | 1 | Oversampling strobe, OVS pulses per bit (asynchronous mode) |
| rxd | input | 1 | Serial data line, idle high |
| data_bits_cfg | input | 2 | Data bit count minus 5 |
| parity_mode | input | 3 | 0 even, 1 odd, 2 forced 0, 3 forced 1, 4-7 none |
| rd_strobe | input | 1 | Collects the held character and clears `rdy` |
| clr_status | input | 1 | Clears the overrun, parity and framing flags |
| rx_data | output | 8 | Holding register |
| rdy | output | 1 | A character is waiting |
| ovr | output | 1 | Overrun (sticky) |
| par_err | output | 1 | Parity error (sticky) |
| frm_err | output | 1 | Framing error (sticky) |

## Verification
The character and its flags become visible a fixed number of clock cycles after the stop bit's sampling point. That delay is the input synchronizer stages, plus one cycle to detect the edge or strobe, plus one register in the frame logic and one in the status logic. The bench therefore checks that `rx_data` and `rdy` are unchanged just before the stop bit starts. It checks the new character and all flags only after two idle bit periods, which is well past that delay. Read and clear pulses act at the next clock edge, so their results are sampled on the following falling edge.

// File: rtl/srx_pkg.sv
package srx_pkg;

   typedef enum logic [1:0] {
      FS_IDLE,
      FS_DATA,
      FS_PAR,
      FS_STOP
   } frame_state_e;

   localparam logic [2:0] PM_EVEN = 3'd0;
   localparam logic [2:0] PM_ODD  = 3'd1;
   localparam logic [2:0] PM_ZERO = 3'd2;

   // parity bit present for modes 0..3
   function automatic logic parity_on(input logic [2:0] mode);
      return mode < 3'd4;
   endfunction

   // expected parity bit given the XOR of the received data bits
   function automatic logic parity_want(input logic [2:0] mode, input logic ones_odd);
      case (mode)
         PM_EVEN: return ones_odd;
         PM_ODD:  return ~ones_odd;
         PM_ZERO: return 1'b0;
         default: return 1'b1;
      endcase
   endfunction

endpackage

// File: rtl/srx_sync.sv
module srx_sync #(
   parameter int   STAGES   = 2,
   parameter logic IDLE_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);

   generate
      if (STAGES == 0) begin : g_bypass
         assign q = d;
      end else begin : g_chain
         logic [STAGES-1:0] r;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               r <= {STAGES{IDLE_VAL}};
            end else begin
               r[0] <= d;
               for (int i = 1; i < STAGES; i++) r[i] <= r[i-1];
            end
         end
         assign q = r[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/srx_sampler.sv
module srx_sampler #(
   parameter int OVS = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sync_mode,
   input  logic line,
   input  logic sclk,
   input  logic tick,
   input  logic frame_end,
   output logic start_pulse,
   output logic bit_pulse
);

   localparam int CW   = $clog2(OVS);
   localparam int HALF = OVS / 2;

   logic          sclk_q;
   logic          in_frame;
   logic          hunting;
   logic          armed;
   logic [CW-1:0] cnt;
   logic          sclk_rise;

   assign sclk_rise = sclk & ~sclk_q;

   always_comb begin
      start_pulse = 1'b0;
      bit_pulse   = 1'b0;
      if (sync_mode) begin
         if (sclk_rise) begin
            if (in_frame)            bit_pulse   = 1'b1;
            else if (armed && !line) start_pulse = 1'b1;
         end
      end else if (tick) begin
         if (in_frame && cnt == CW'(OVS-1))                    bit_pulse   = 1'b1;
         else if (!in_frame && hunting && cnt == CW'(HALF-1) && !line) start_pulse = 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sclk_q   <= 1'b0;
         in_frame <= 1'b0;
         hunting  <= 1'b0;
         armed    <= 1'b0;
         cnt      <= '0;
      end else begin
         sclk_q <= sclk;
         if (frame_end) begin
            in_frame <= 1'b0;
            hunting  <= 1'b0;
            armed    <= 1'b0;
         end else if (start_pulse) begin
            in_frame <= 1'b1;
            hunting  <= 1'b0;
            cnt      <= '0;
         end else begin
            if (!in_frame && line) armed <= 1'b1;
            if (sync_mode) begin
               hunting <= 1'b0;
            end else if (tick) begin
               if (in_frame) begin
                  cnt <= (cnt == CW'(OVS-1)) ? '0 : cnt + 1'b1;
               end else if (hunting) begin
                  if (cnt == CW'(HALF-1)) hunting <= 1'b0;
                  else                    cnt     <= cnt + 1'b1;
               end else if (armed && !line) begin
                  hunting <= 1'b1;
                  cnt     <= '0;
               end
            end
         end
      end
   end

endmodule

// File: rtl/srx_frame.sv
module srx_frame
   import srx_pkg::*;
#(
   parameter int MAX_BITS = 8,
   parameter int MIN_BITS = 5,
   parameter int CFG_W    = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                start_pulse,
   input  logic                bit_pulse,
   input  logic                line,
   input  logic [CFG_W-1:0]    nbits_cfg,
   input  logic [2:0]          par_mode,
   output logic                frame_end,
   output logic                char_done,
   output logic [MAX_BITS-1:0] char_data,
   output logic                char_par_bad,
   output logic                char_frm_bad
);

   localparam int IDX_W = $clog2(MAX_BITS);

   frame_state_e        state;
   logic [IDX_W-1:0]    idx;
   logic [IDX_W-1:0]    last_idx;
   logic [MAX_BITS-1:0] shreg;
   logic                par_bit;

   assign last_idx  = IDX_W'(MIN_BITS-1) + IDX_W'(nbits_cfg);
   assign frame_end = (state == FS_STOP) && bit_pulse;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state        <= FS_IDLE;
         idx          <= '0;
         shreg        <= '0;
         par_bit      <= 1'b0;
         char_done    <= 1'b0;
         char_data    <= '0;
         char_par_bad <= 1'b0;
         char_frm_bad <= 1'b0;
      end else begin
         char_done <= 1'b0;
         case (state)
            FS_IDLE: begin
               if (start_pulse) begin
                  state <= FS_DATA;
                  idx   <= '0;
                  shreg <= '0;
               end
            end
            FS_DATA: begin
               if (bit_pulse) begin
                  shreg[idx] <= line;
                  if (idx == last_idx) state <= parity_on(par_mode) ? FS_PAR : FS_STOP;
                  else                 idx   <= idx + 1'b1;
               end
            end
            FS_PAR: begin
               if (bit_pulse) begin
                  par_bit <= line;
                  state   <= FS_STOP;
               end
            end
            default: begin
               if (bit_pulse) begin
                  char_done    <= 1'b1;
                  char_data    <= shreg;
                  char_par_bad <= parity_on(par_mode) &&
                                  (par_bit != parity_want(par_mode, ^shreg));
                  char_frm_bad <= !line && (|shreg);
                  state        <= FS_IDLE;
               end
            end
         endcase
      end
   end

endmodule

// File: rtl/srx_status.sv
module srx_status #(
   parameter int MAX_BITS = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                char_done,
   input  logic [MAX_BITS-1:0] char_data,
   input  logic                char_par_bad,
   input  logic                char_frm_bad,
   input  logic                rd_strobe,
   input  logic                clr_status,
   output logic [MAX_BITS-1:0] rx_data,
   output logic                rdy,
   output logic                ovr,
   output logic                par_err,
   output logic                frm_err
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx_data <= '0;
         rdy     <= 1'b0;
         ovr     <= 1'b0;
         par_err <= 1'b0;
         frm_err <= 1'b0;
      end else begin
         if (char_done) begin
            rx_data <= char_data;
            rdy     <= 1'b1;
         end else if (rd_strobe) begin
            rdy <= 1'b0;
         end
         // a new error in the same cycle as a clear wins
         ovr     <= (ovr     && !clr_status) || (char_done && rdy && !rd_strobe);
         par_err <= (par_err && !clr_status) || (char_done && char_par_bad);
         frm_err <= (frm_err && !clr_status) || (char_done && char_frm_bad);
      end
   end

endmodule

// File: rtl/serial_rx_core.sv
module serial_rx_core #(
   parameter  int OVS         = 16,
   parameter  int SYNC_STAGES = 2,
   parameter  int MAX_BITS    = 8,
   parameter  int MIN_BITS    = 5,
   localparam int CFG_W       = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                sync_mode,
   input  logic                sclk,
   input  logic                tick,
   input  logic                rxd,
   input  logic [CFG_W-1:0]    data_bits_cfg,
   input  logic [2:0]          parity_mode,
   input  logic                rd_strobe,
   input  logic                clr_status,
   output logic [MAX_BITS-1:0] rx_data,
   output logic                rdy,
   output logic                ovr,
   output logic                par_err,
   output logic                frm_err
);

   generate
      if (OVS < 4 || (OVS % 2) != 0) begin : g_bad_ovs
         $error("OVS must be even and at least 4");
      end
      if (SYNC_STAGES < 0 || SYNC_STAGES > 4) begin : g_bad_sync
         $error("SYNC_STAGES must be within 0..4");
      end
      if (MIN_BITS < 1 || MAX_BITS < MIN_BITS || (MAX_BITS - MIN_BITS) > 3) begin : g_bad_bits
         $error("data bit range must span 1..4 values");
      end
   endgenerate

   logic                line_s;
   logic                sclk_s;
   logic                start_pulse;
   logic                bit_pulse;
   logic                frame_end;
   logic                char_done;
   logic [MAX_BITS-1:0] char_data;
   logic                char_par_bad;
   logic                char_frm_bad;

   srx_sync #(.STAGES(SYNC_STAGES), .IDLE_VAL(1'b1)) u_sync_rxd (
      .clk(clk), .rst_n(rst_n), .d(rxd), .q(line_s)
   );

   srx_sync #(.STAGES(SYNC_STAGES), .IDLE_VAL(1'b0)) u_sync_sclk (
      .clk(clk), .rst_n(rst_n), .d(sclk), .q(sclk_s)
   );

   srx_sampler #(.OVS(OVS)) u_sampler (
      .clk         (clk),
      .rst_n       (rst_n),
      .sync_mode   (sync_mode),
      .line        (line_s),
      .sclk        (sclk_s),
      .tick        (tick),
      .frame_end   (frame_end),
      .start_pulse (start_pulse),
      .bit_pulse   (bit_pulse)
   );

   srx_frame #(.MAX_BITS(MAX_BITS), .MIN_BITS(MIN_BITS), .CFG_W(CFG_W)) u_frame (
      .clk          (clk),
      .rst_n        (rst_n),
      .start_pulse  (start_pulse),
      .bit_pulse    (bit_pulse),
      .line         (line_s),
      .nbits_cfg    (data_bits_cfg),
      .par_mode     (parity_mode),
      .frame_end    (frame_end),
      .char_done    (char_done),
      .char_data    (char_data),
      .char_par_bad (char_par_bad),
      .char_frm_bad (char_frm_bad)
   );

   srx_status #(.MAX_BITS(MAX_BITS)) u_status (
      .clk          (clk),
      .rst_n        (rst_n),
      .char_done    (char_done),
      .char_data    (char_data),
      .char_par_bad (char_par_bad),
      .char_frm_bad (char_frm_bad),
      .rd_strobe    (rd_strobe),
      .clr_status   (clr_status),
      .rx_data      (rx_data),
      .rdy          (rdy),
      .ovr          (ovr),
      .par_err      (par_err),
      .frm_err      (frm_err)
   );

endmodule

// File: rtl/srx_checker.sv
module srx_checker #(
   parameter int MAX_BITS = 8
) (
   input logic                clk,
   input logic                rst_n,
   input logic                char_done,
   input logic                rd_strobe,
   input logic                clr_status,
   input logic [MAX_BITS-1:0] rx_data,
   input logic                rdy,
   input logic                ovr,
   input logic                par_err,
   input logic                frm_err
);

   assert_hold_between_chars_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !char_done |=> $stable(rx_data));

   assert_ready_after_stop_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rdy) |-> $past(char_done));

   assert_overrun_on_unread_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (char_done && rdy && !rd_strobe) |=> ovr);

   assert_read_clears_ready_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_strobe && !char_done) |=> !rdy);

   assert_sticky_overrun_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (ovr && !clr_status) |=> ovr);

   assert_sticky_parity_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (par_err && !clr_status) |=> par_err);

   assert_clear_flags_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_status && !char_done) |=> (!ovr && !par_err && !frm_err));

endmodule

bind serial_rx_core srx_checker #(.MAX_BITS(MAX_BITS)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .char_done  (char_done),
   .rd_strobe  (rd_strobe),
   .clr_status (clr_status),
   .rx_data    (rx_data),
   .rdy        (rdy),
   .ovr        (ovr),
   .par_err    (par_err),
   .frm_err    (frm_err)
);

// File: tb/serial_rx_core_bench.sv
`timescale 1ns/1ps
module serial_rx_core_bench;

   localparam int OVS = 8;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       sync_mode = 1'b0;
   logic       sclk = 1'b0;
   logic       tick = 1'b0;
   logic       rxd = 1'b1;
   logic [1:0] data_bits_cfg = 2'd3;
   logic [2:0] parity_mode = 3'd0;
   logic       rd_strobe = 1'b0;
   logic       clr_status = 1'b0;
   logic [7:0] rx_data;
   logic       rdy, ovr, par_err, frm_err;

   int checks = 0;
   int failures = 0;
   bit finished = 0;

   logic [7:0] exp_data = 8'd0;
   logic       exp_rdy = 0, exp_ovr = 0, exp_par = 0, exp_frm = 0;

   serial_rx_core #(.OVS(OVS), .SYNC_STAGES(2)) u_serial_rx_core (
      .clk(clk), .rst_n(rst_n), .sync_mode(sync_mode), .sclk(sclk), .tick(tick),
      .rxd(rxd), .data_bits_cfg(data_bits_cfg), .parity_mode(parity_mode),
      .rd_strobe(rd_strobe), .clr_status(clr_status), .rx_data(rx_data),
      .rdy(rdy), .ovr(ovr), .par_err(par_err), .frm_err(frm_err)
   );

   always #2.5 clk = ~clk;

   initial begin
      forever begin
         @(negedge clk);
         tick = ~tick;
      end
   end

   task automatic chk(input bit ok, input string req, input int act, input int expv);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
      end
   endtask

   function automatic logic par_bit_for(input logic [2:0] pm, input logic [7:0] m);
      case (pm)
         3'd0: return ^m;
         3'd1: return ~(^m);
         3'd2: return 1'b0;
         default: return 1'b1;
      endcase
   endfunction

   task automatic send_bit(input logic v);
      if (sync_mode) begin
         rxd  = v;
         sclk = 1'b0;
         repeat (4) @(negedge clk);
         sclk = 1'b1;
         repeat (4) @(negedge clk);
      end else begin
         rxd = v;
         repeat (2*OVS) @(negedge clk);
      end
   endtask

   task automatic check_all(input string data_req);
      chk(rx_data === exp_data, data_req, rx_data, exp_data);
      chk(rdy === exp_rdy, "R1 ready", rdy, exp_rdy);
      chk(ovr === exp_ovr, "R2 overrun", ovr, exp_ovr);
      chk(par_err === exp_par, "R3 parity flag", par_err, exp_par);
      chk(frm_err === exp_frm, "R5 framing flag", frm_err, exp_frm);
   endtask

   task automatic send_char(input logic smode, input logic [7:0] d, input logic [1:0] cfg,
                            input logic [2:0] pm, input logic perr, input logic stopv,
                            input string req);
      int nb;
      logic [7:0] m;
      nb = 5 + int'(cfg);
      m  = d & 8'((9'd1 << nb) - 9'd1);
      @(negedge clk);
      sync_mode     = smode;
      data_bits_cfg = cfg;
      parity_mode   = pm;
      send_bit(1'b0);
      for (int i = 0; i < nb; i++) send_bit(m[i]);
      if (pm < 3'd4) send_bit(par_bit_for(pm, m) ^ perr);
      // nothing may change before the stop bit
      chk(rdy === exp_rdy && rx_data === exp_data, "R1 early", {rdy, rx_data}, {exp_rdy, exp_data});
      send_bit(stopv);
      send_bit(1'b1);
      send_bit(1'b1);
      if (exp_rdy) exp_ovr = 1'b1;
      exp_rdy  = 1'b1;
      exp_data = m;
      if (pm < 3'd4 && perr) exp_par = 1'b1;
      if (!stopv && m != 8'd0) exp_frm = 1'b1;
      check_all(req);
   endtask

   task automatic do_read();
      @(negedge clk) rd_strobe = 1'b1;
      @(negedge clk) rd_strobe = 1'b0;
      exp_rdy = 1'b0;
      chk(rdy === 1'b0, "R6 read clears", rdy, 0);
   endtask

   task automatic do_clear();
      @(negedge clk) clr_status = 1'b1;
      @(negedge clk) clr_status = 1'b0;
      exp_ovr = 0; exp_par = 0; exp_frm = 0;
      chk({ovr, par_err, frm_err} === 3'b000, "R7 clear", {ovr, par_err, frm_err}, 0);
   endtask

   initial begin
      void'($urandom(32'h5eed_c0de));
      repeat (5) @(negedge clk);
      chk({rdy, ovr, par_err, frm_err} === 4'b0 && rx_data === 8'd0, "R1 reset",
          {rdy, ovr, par_err, frm_err, rx_data}, 0);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);

      // R9: synchronous, 8 bits, even parity, 1 stop
      send_char(1'b1, 8'hA5, 2'd3, 3'd0, 1'b0, 1'b1, "R9 sync data");
      do_read();
      // R8/R4: 5 bits, no parity (code 4), upper bits zero
      send_char(1'b1, 8'hFB, 2'd0, 3'd4, 1'b0, 1'b1, "R8 five bits");
      do_read();
      send_char(1'b0, 8'hC6, 2'd1, 3'd7, 1'b0, 1'b1, "R4 no parity");
      do_read();
      // R3: each parity rule with an error injected
      for (int pm = 0; pm < 4; pm++) begin
         send_char(1'b0, 8'h3C, 2'd3, 3'(pm), 1'b1, 1'b1, "R3 parity error");
         do_read();
         chk(par_err === 1'b1, "R3 par_err set", par_err, 1);
         do_clear();
      end
      // R5: break is not a framing error, a nonzero character is
      send_char(1'b0, 8'h00, 2'd3, 3'd1, 1'b0, 1'b0, "R5 break");
      chk(frm_err === 1'b0, "R5 break no framing", frm_err, 0);
      do_read();
      send_char(1'b1, 8'h40, 2'd2, 3'd4, 1'b0, 1'b0, "R5 framing");
      do_read();
      // R7: flag survives a clean character
      send_char(1'b0, 8'h11, 2'd3, 3'd2, 1'b0, 1'b1, "R7 sticky");
      chk(frm_err === 1'b1, "R7 framing sticky", frm_err, 1);
      do_read();
      do_clear();
      // R2: two characters without a read
      send_char(1'b0, 8'h5A, 2'd3, 3'd0, 1'b0, 1'b1, "R2 first");
      send_char(1'b1, 8'h69, 2'd3, 3'd3, 1'b0, 1'b1, "R2 second");
      chk(ovr === 1'b1, "R2 overrun set", ovr, 1);
      do_read();
      do_clear();
      // R10: short low pulse is not a start
      @(negedge clk);
      sync_mode = 1'b0;
      rxd = 1'b0;
      repeat (2) @(negedge clk);
      rxd = 1'b1;
      repeat (24*OVS) @(negedge clk);
      chk(rdy === 1'b0, "R10 glitch ignored", rdy, 0);
      send_char(1'b0, 8'h96, 2'd3, 3'd0, 1'b0, 1'b1, "R10 after glitch");
      do_read();

      // random mix
      for (int n = 0; n < 40; n++) begin
         logic sm, pe, sv;
         logic [7:0] d;
         logic [1:0] cf;
         logic [2:0] pm;
         sm = 1'($urandom % 2);
         d  = 8'($urandom);
         cf = 2'($urandom % 4);
         pm = 3'($urandom % 6);
         pe = ($urandom % 6) == 0;
         sv = ($urandom % 8) != 0;
         send_char(sm, d, cf, pm, pe, sv, "R8 random data");
         if (($urandom % 3) != 0) do_read();
         if (($urandom % 4) == 0) do_clear();
      end

      if (!finished) begin
         finished = 1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      #1000000;
      if (!finished) begin
         finished = 1;
         checks++;
         failures++;
         $display("FAIL watchdog expired actual=0 expected=1");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule